// File: doc/BRIEF.md
# Sample Count and Periodic Timer Interrupt Unit

This block keeps two sample counters and one periodic timer, and it raises a host interrupt when any of them rolls under. Software loads each 16-bit base value as two byte writes through a small byte-wide register port. The playback and capture counters step down once per one-cycle sample strobe. When a counter is at zero and receives a strobe, it reloads from its base register and sets its interrupt flag.

The timer steps down once per time-base tick. The tick comes from dividing the block clock by one of two ratios, chosen by a select input. The timer reloads and keeps running while its flag is still pending, so its interrupts stay evenly spaced however late software services them.

Two extra sticky bits record playback underrun and capture overrun events next to the three interrupt flags. Software can clear flags in two ways: one write to the status address clears all three interrupt flags at once, or writing 0 to a single bit of the flag register clears that bit alone. A single-channel mode lets one counter serve both sample directions.

Top module: `smpcnt_timer_irq`

## Requirements
- R1: The base registers are written and read back byte by byte at these addresses: 0 playback low, 1 playback high, 2 capture low, 3 capture high, 4 timer low, 5 timer high. A read returns the value that was written. After reset every register reads 0.
- R2: Writing the high byte of a base loads its current counter with the full 16-bit base. With base N, the flag sets on strobe N+1. At that strobe the counter reloads to N in the same cycle, so the next flag comes N+1 strobes later.
- R3: In dual mode, a playback roll-under sets flag bit 0 and a capture roll-under sets flag bit 1. The flag register is at address 7.
- R4: With control bit 1 (single-channel) set, capture strobes step the playback counter and set flag bit 0. The capture counter and flag bit 1 stay untouched. The control register is at address 6.
- R5: The current counters are never readable. Addresses 9 to 15 read 0.
- R6: While control bit 2 (timer enable) is set, a tick occurs every 245 clocks with clk_sel=0 and every 168 clocks with clk_sel=1. With timer base N, flag bit 2 first sets (N+1) ticks after the enabling write.
- R7: The timer keeps counting while flag bit 2 is pending. It reloads on every roll-under, so the k-th roll-under falls exactly k*(N+1) ticks after enable.
- R8: Any write to address 8 (status) clears flag bits 0 to 2.
- R9: A write to address 7 clears each flag bit written as 0 and leaves each bit written as 1 unchanged.
- R10: A flag-setting event and a clear of that flag in the same cycle leave the flag set.
- R11: int_sum and status bit 0 are the OR of flag bits 0 to 2. irq is int_sum gated by control bit 0 (irq enable).
- R12: play_urun sets flag bit 3 and cap_orun sets flag bit 4. Both bits are cleared only by R9 writes, survive status writes, and do not drive irq or int_sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the timer time-base source |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| play_stb | input | 1 | One-cycle playback sample strobe |
| cap_stb | input | 1 | One-cycle capture sample strobe |
| play_urun | input | 1 | Playback underrun event |
| cap_orun | input | 1 | Capture overrun event |
| clk_sel | input | 1 | Time-base divider select |
| irq | output | 1 | Gated host interrupt |
| int_sum | output | 1 | Ungated interrupt summary |

## Verification
Every strobe and register write takes effect at the clock edge where it is seen. Its flag is therefore readable at the falling edge right after that edge, so each directed task reads flags half a cycle after the edge that should change them.

The bench drives inputs on the falling edge and samples on the falling edge. Timer results are counted in whole clocks from the enabling write. The expected first roll-under at (N+1) times the divider, and the second at twice that, are checked exactly, with a flag clear placed between them.

// File: rtl/smpcnt_timer_irq.sv
module smpcnt_timer_irq #(
  parameter int CNT_W = 16,
  parameter int DIV_A = 245,
  parameter int DIV_B = 168
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       play_stb,
  input  logic       cap_stb,
  input  logic       play_urun,
  input  logic       cap_orun,
  input  logic       clk_sel,
  output logic       irq,
  output logic       int_sum
);
  localparam int HI_W    = CNT_W - 8;
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int PRE_W   = $clog2(DIV_MAX);
  localparam logic [3:0] A_PLO = 4'd0, A_PHI = 4'd1, A_CLO = 4'd2, A_CHI = 4'd3,
                         A_TLO = 4'd4, A_THI = 4'd5, A_CTL = 4'd6, A_FLG = 4'd7,
                         A_STA = 4'd8;

  logic [CNT_W-1:0] play_base, cap_base, tmr_base;
  logic [CNT_W-1:0] play_cnt, cap_cnt, tmr_cnt;
  logic [PRE_W-1:0] pre;
  logic [2:0]       ctrl;
  logic [4:0]       flags;

  wire irq_en = ctrl[0];
  wire single = ctrl[1];
  wire tmr_en = ctrl[2];

  wire wr_phi = wr_en && addr == A_PHI;
  wire wr_chi = wr_en && addr == A_CHI;
  wire wr_thi = wr_en && addr == A_THI;
  wire wr_flg = wr_en && addr == A_FLG;
  wire wr_sta = wr_en && addr == A_STA;

  wire play_dec  = play_stb || (single && cap_stb);
  wire cap_dec   = cap_stb && !single;
  wire play_roll = play_dec && play_cnt == '0;
  wire cap_roll  = cap_dec && cap_cnt == '0;

  wire [PRE_W-1:0] lim_m1 = clk_sel ? PRE_W'(DIV_B - 1) : PRE_W'(DIV_A - 1);
  wire tick     = tmr_en && pre >= lim_m1;
  wire tmr_roll = tick && tmr_cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_base <= '0;
      cap_base  <= '0;
      tmr_base  <= '0;
      ctrl      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PLO: play_base[7:0]       <= wr_data;
        A_PHI: play_base[CNT_W-1:8] <= wr_data[HI_W-1:0];
        A_CLO: cap_base[7:0]        <= wr_data;
        A_CHI: cap_base[CNT_W-1:8]  <= wr_data[HI_W-1:0];
        A_TLO: tmr_base[7:0]        <= wr_data;
        A_THI: tmr_base[CNT_W-1:8]  <= wr_data[HI_W-1:0];
        A_CTL: ctrl                 <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        play_cnt <= '0;
    else if (wr_phi)   play_cnt <= {wr_data[HI_W-1:0], play_base[7:0]};
    else if (play_dec) play_cnt <= play_roll ? play_base : play_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cap_cnt <= '0;
    else if (wr_chi)  cap_cnt <= {wr_data[HI_W-1:0], cap_base[7:0]};
    else if (cap_dec) cap_cnt <= cap_roll ? cap_base : cap_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tmr_en) pre <= '0;
    else if (tick)         pre <= '0;
    else                   pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr_cnt <= '0;
    else if (wr_thi) tmr_cnt <= {wr_data[HI_W-1:0], tmr_base[7:0]};
    else if (tick)   tmr_cnt <= tmr_roll ? tmr_base : tmr_cnt - 1'b1;
  end

  wire [4:0] f_set = {cap_orun, play_urun, tmr_roll, cap_roll, play_roll};
  wire [4:0] f_clr = ({5{wr_flg}} & ~wr_data[4:0]) | {2'b00, {3{wr_sta}}};

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~f_clr) | f_set;
  end

  assign int_sum = |flags[2:0];
  assign irq     = irq_en && int_sum;

  always_comb begin
    case (addr)
      A_PLO:   rd_data = play_base[7:0];
      A_PHI:   rd_data = 8'(play_base[CNT_W-1:8]);
      A_CLO:   rd_data = cap_base[7:0];
      A_CHI:   rd_data = 8'(cap_base[CNT_W-1:8]);
      A_TLO:   rd_data = tmr_base[7:0];
      A_THI:   rd_data = 8'(tmr_base[CNT_W-1:8]);
      A_CTL:   rd_data = {5'b0, ctrl};
      A_FLG:   rd_data = {3'b0, flags};
      A_STA:   rd_data = {7'b0, int_sum};
      default: rd_data = 8'h00;
    endcase
  end

  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (play_roll && !wr_phi) |=> play_cnt == $past(play_base));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (play_dec && play_cnt != '0 && !wr_phi) |=> play_cnt == $past(play_cnt) - CNT_W'(1));
  a_r3_play_flag: assert property (@(posedge clk) disable iff (!rst_n)
    play_roll |=> flags[0]);
  a_r4_cap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (single && !wr_chi) |=> $stable(cap_cnt));
  a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PRE_W'(DIV_MAX - 1));
  a_r7_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tmr_cnt != '0 && flags[2] && !wr_thi) |=> tmr_cnt == $past(tmr_cnt) - CNT_W'(1));
  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sta && !play_roll && !cap_roll && !tmr_roll) |=> flags[2:0] == 3'b000);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_roll && (wr_sta || wr_flg)) |=> flags[2]);
endmodule

// File: tb/tb_smpcnt_timer_irq.sv
`timescale 1ns/1ps
module tb_smpcnt_timer_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic play_stb = 1'b0, cap_stb = 1'b0, play_urun = 1'b0, cap_orun = 1'b0, clk_sel = 1'b0;
  logic [7:0] rd_data;
  logic irq, int_sum;
  int n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  smpcnt_timer_irq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .play_stb(play_stb), .cap_stb(cap_stb), .play_urun(play_urun),
    .cap_orun(cap_orun), .clk_sel(clk_sel), .irq(irq), .int_sum(int_sum));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(input logic p, input logic c);
    play_stb = p; cap_stb = c;
    @(posedge clk); @(negedge clk);
    play_stb = 1'b0; cap_stb = 1'b0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) begin
      reg_rd(a[3:0], v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R11 reset irq", irq, 0);
    chk("R11 reset int_sum", int_sum, 0);
  endtask

  task automatic t_base_rw;
    for (int a = 0; a < 6; a++) reg_wr(a[3:0], 8'h11 * (a + 1));
    for (int a = 0; a < 6; a++) begin
      reg_rd(a[3:0], v);
      chk($sformatf("R1 readback addr %0d", a), v, 8'h11 * (a + 1));
    end
    for (int a = 9; a < 16; a++) begin
      reg_rd(a[3:0], v);
      chk($sformatf("R5 hidden counter addr %0d", a), v, 0);
    end
  endtask

  task automatic t_play_count;
    reg_wr(6, 8'h01);
    reg_wr(0, 8'd3); reg_wr(1, 8'd0);
    repeat (3) pulse(1, 0);
    reg_rd(7, v); chk("R2 no flag after N strobes", v, 0);
    pulse(1, 0);
    reg_rd(7, v); chk("R3 play flag on strobe N+1", v, 8'h01);
    chk("R11 irq with enable", irq, 1);
    chk("R11 int_sum", int_sum, 1);
    reg_wr(7, 8'h1E);
    reg_rd(7, v); chk("R9 write 0 clears play flag", v, 0);
    repeat (3) pulse(1, 0);
    reg_rd(7, v); chk("R2 reload no early flag", v, 0);
    pulse(1, 0);
    reg_rd(7, v); chk("R2 reload periodic flag", v, 8'h01);
    reg_wr(8, 8'h00);
  endtask

  task automatic t_cap_count;
    reg_wr(2, 8'd1); reg_wr(3, 8'd0);
    pulse(0, 1);
    reg_rd(7, v); chk("R3 cap no flag yet", v, 0);
    pulse(0, 1);
    reg_rd(7, v); chk("R3 cap flag bit1", v, 8'h02);
    reg_wr(8, 8'h5A);
    reg_rd(7, v); chk("R8 status write clears", v, 0);
  endtask

  task automatic t_single;
    reg_wr(6, 8'h03);
    reg_wr(0, 8'd1); reg_wr(1, 8'd0);
    pulse(0, 1); pulse(0, 1);
    reg_rd(7, v); chk("R4 single cap sets play flag", v, 8'h01);
    reg_wr(6, 8'h01);
    reg_wr(8, 8'h00);
    pulse(0, 1);
    reg_rd(7, v); chk("R4 cap counter untouched step", v, 0);
    pulse(0, 1);
    reg_rd(7, v); chk("R4 cap counter untouched roll", v, 8'h02);
  endtask

  task automatic t_gate_and_clear;
    reg_wr(0, 8'd0); reg_wr(1, 8'd0);
    pulse(1, 0);
    reg_rd(7, v); chk("R9 both flags set", v, 8'h03);
    reg_wr(6, 8'h00);
    chk("R11 irq gated off", irq, 0);
    chk("R11 int_sum ungated", int_sum, 1);
    reg_rd(8, v); chk("R11 status bit0", v, 8'h01);
    reg_wr(6, 8'h01);
    chk("R11 irq regated on", irq, 1);
    reg_wr(7, 8'h1D);
    reg_rd(7, v); chk("R9 selective clear", v, 8'h01);
    reg_wr(8, 8'hFF);
    reg_rd(7, v); chk("R8 clear all", v, 0);
  endtask

  task automatic t_set_wins;
    wr_en = 1'b1; addr = 8; wr_data = 8'h00; play_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; play_stb = 1'b0;
    reg_rd(7, v); chk("R10 status clear vs set", v, 8'h01);
    wr_en = 1'b1; addr = 7; wr_data = 8'h00; play_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; play_stb = 1'b0;
    reg_rd(7, v); chk("R10 bit clear vs set", v, 8'h01);
    reg_wr(8, 8'h00);
  endtask

  task automatic t_sticky;
    play_urun = 1'b1; @(posedge clk); @(negedge clk); play_urun = 1'b0;
    reg_rd(7, v); chk("R12 underrun bit3", v, 8'h08);
    chk("R12 no irq from underrun", irq, 0);
    chk("R12 no int_sum from underrun", int_sum, 0);
    reg_wr(8, 8'h00);
    reg_rd(7, v); chk("R12 survives status write", v, 8'h08);
    cap_orun = 1'b1; @(posedge clk); @(negedge clk); cap_orun = 1'b0;
    reg_rd(7, v); chk("R12 overrun bit4", v, 8'h18);
    reg_wr(7, 8'h17);
    reg_rd(7, v); chk("R12 cleared by write 0", v, 8'h10);
    reg_wr(7, 8'h00);
  endtask

  task automatic wait_timer(output int cyc, input int start);
    cyc = start;
    addr = 7;
    while (cyc < 5000) begin
      @(negedge clk); cyc++;
      #1;
      if (rd_data[2]) break;
    end
  endtask

  task automatic t_timer;
    int c;
    reg_wr(4, 8'd2); reg_wr(5, 8'd0);
    clk_sel = 1'b0;
    reg_wr(6, 8'h05);
    wait_timer(c, 0);
    chk("R6 first roll at 3*245", c, 735);
    chk("R11 irq from timer", irq, 1);
    reg_wr(7, 8'h1B);
    wait_timer(c, c + 1);
    chk("R7 second roll at 6*245", c, 1470);
    reg_wr(6, 8'h01);
    reg_wr(5, 8'd0);
    reg_wr(8, 8'h00);
    clk_sel = 1'b1;
    reg_wr(6, 8'h05);
    wait_timer(c, 0);
    chk("R6 roll at 3*168", c, 504);
    reg_wr(6, 8'h01);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_rw();
    t_play_count();
    t_cap_count();
    t_single();
    t_gate_and_clear();
    t_set_wins();
    t_sticky();
    t_timer();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule